// File: doc/BRIEF.md
# Load Writeback Formatter with Post-Increment

This block sits after the data return of a load pipeline. It takes the raw bytes that memory returned for one load and forms what the register file receives. That is the destination value and its deferred-exception tag (NaT), a second 64-bit word for the paired 16-byte load, and the post-incremented base register with its own NaT. It also raises a prefetch request at the new base address and flags illegal or faulting encodings.

Memory access, translation and the register file stay outside the block. The caller presents one load per cycle with `in_valid`. Every result appears on registered outputs exactly one cycle later, with no backpressure. The caller performs every write whose enable is high.

A fault (illegal encoding or NaT consumption) suppresses all writes and the prefetch for that load.

Top module: `ldres_unit`

## Requirements
- R1: For the plain form (`in_form`=0), size code 0/1/2/3 selects 1/2/4/8 bytes of `in_data_lo`. The selected bytes are zero-extended into `out_dst_val`, `out_dst_nat` is 0 and `out_dst_we` is 1.
- R2: For the fill form (`in_form`=1), all 64 bits of `in_data_lo` go to the destination regardless of size. `out_dst_nat` equals bit `in_base[8:3]` of `in_spill`.
- R3: For the paired form (`in_form`=2), `in_data_lo` goes to `out_dst_val` with NaT 0, and `in_data_hi` goes to `out_pair_val` with `out_pair_we`=1. Requesting a base update with this form is illegal.
- R4: Update code 1 adds the sign-extended 9-bit `in_imm` to `in_base`, and update code 2 adds `in_inc`. The sum appears on `out_base_val` with `out_base_we`=1, and the base update never alters the loaded value. Code 0 (and 3) means no update.
- R5: With update code 2, `out_base_nat` is the OR of `in_base_nat` and `in_inc_nat`, and `in_inc_nat` alone raises no fault. With code 1, `out_base_nat` equals `in_base_nat`.
- R6: An update request whose `in_dst_reg` equals `in_base_reg`, or any update with the paired form, sets `out_illegal`. In that case all write enables and the prefetch are 0.
- R7: A load is deferred when `in_defer` is set, or when it is speculative and `in_base_nat` is set. A deferred speculative load writes 0 with NaT 1. A deferred non-speculative load writes 0 with NaT 0. No pair write occurs in either case.
- R8: A legal non-speculative load with `in_base_nat` set raises `out_nat_fault`, and all writes and the prefetch are suppressed.
- R9: `out_pf_req` is 1 exactly when the base is written with NaT 0. `out_pf_addr` then equals the updated base.
- R10: `out_valid` follows `in_valid` by one cycle. After reset, `out_valid`, all write enables, `out_pf_req`, `out_illegal` and `out_nat_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load result present |
| in_form | input | 2 | 0 plain, 1 fill, 2 paired |
| in_size | input | 2 | Access size code (1,2,4,8 bytes) |
| in_spec | input | 1 | Speculative load |
| in_defer | input | 1 | Exception deferred upstream |
| in_data_lo | input | 64 | Lower-address memory word |
| in_data_hi | input | 64 | Higher-address memory word |
| in_base | input | 64 | Base address register value |
| in_base_nat | input | 1 | Base register NaT |
| in_upd | input | 2 | 0 none, 1 immediate, 2 register |
| in_imm | input | 9 | Signed immediate increment |
| in_inc | input | 64 | Register increment |
| in_inc_nat | input | 1 | Increment register NaT |
| in_spill | input | 64 | Spill-NaT collection word |
| in_dst_reg | input | 7 | Destination register number |
| in_base_reg | input | 7 | Base register number |
| out_valid | output | 1 | Result valid |
| out_dst_we | output | 1 | Destination write enable |
| out_dst_val | output | 64 | Destination value |
| out_dst_nat | output | 1 | Destination NaT |
| out_pair_we | output | 1 | Second data register write enable |
| out_pair_val | output | 64 | Second data register value |
| out_base_we | output | 1 | Base register write enable |
| out_base_val | output | 64 | Updated base value |
| out_base_nat | output | 1 | Updated base NaT |
| out_pf_req | output | 1 | Prefetch request |
| out_pf_addr | output | 64 | Prefetch address |
| out_illegal | output | 1 | Illegal-operation fault |
| out_nat_fault | output | 1 | NaT-consumption fault |

## Verification
Plain loads run every size code with data whose upper bytes are all ones, so a wrong extension mask shows at once. Fill loads move the base address so that bits 8:3 sweep the spill word, which separates a correct index from an off-by-one or fixed bit. Negative immediates and increment NaTs on either operand separate sign extension and NaT merging from a plain add. Aliased registers, paired-with-update, speculative and non-speculative base NaTs and upstream deferral are each driven alone and then mixed with random traffic, so the priority between fault, deferral and normal result is pinned down.

// File: rtl/ldres_pkg.sv
package ldres_pkg;
   typedef enum logic [1:0] {
      LF_PLAIN = 2'd0,
      LF_FILL  = 2'd1,
      LF_PAIR  = 2'd2
   } ld_form_e;

   typedef enum logic [1:0] {
      BU_NONE = 2'd0,
      BU_IMM  = 2'd1,
      BU_REG  = 2'd2
   } base_upd_e;
endpackage

// File: rtl/ldres_format.sv
module ldres_format
   import ldres_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int SZ_CODES = 4,
   localparam int SZW     = $clog2(SZ_CODES),
   localparam int IDXW    = $clog2(XLEN)
) (
   input  logic [1:0]      form,
   input  logic [SZW-1:0]  size,
   input  logic            spec,
   input  logic            deferred,
   input  logic [XLEN-1:0] data_lo,
   input  logic [XLEN-1:0] data_hi,
   input  logic [XLEN-1:0] spill,
   input  logic [IDXW-1:0] spill_idx,
   output logic [XLEN-1:0] val,
   output logic            nat,
   output logic [XLEN-1:0] pair_val,
   output logic            pair_we
);
   logic [XLEN-1:0] ext [SZ_CODES];

   // one zero-extension variant per size code
   for (genvar g = 0; g < SZ_CODES; g++) begin : g_ext
      localparam int BITS = 8 * (1 << g);
      if (BITS > XLEN) begin : g_bad
         $error("size code %0d exceeds register width", g);
      end else if (BITS == XLEN) begin : g_full
         assign ext[g] = data_lo;
      end else begin : g_part
         assign ext[g] = {{(XLEN-BITS){1'b0}}, data_lo[BITS-1:0]};
      end
   end

   always_comb begin
      val      = '0;
      nat      = 1'b0;
      pair_val = data_hi;
      pair_we  = 1'b0;
      if (deferred) begin
         nat = spec;
      end else begin
         unique case (ld_form_e'(form))
            LF_FILL: begin
               val = data_lo;
               nat = spill[spill_idx];
            end
            LF_PAIR: begin
               val     = data_lo;
               pair_we = 1'b1;
            end
            default: val = ext[size];
         endcase
      end
   end
endmodule

// File: rtl/ldres_baseupd.sv
module ldres_baseupd
   import ldres_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int IMMW = 9
) (
   input  logic [1:0]      upd,
   input  logic [XLEN-1:0] base,
   input  logic            base_nat,
   input  logic [IMMW-1:0] imm,
   input  logic [XLEN-1:0] inc,
   input  logic            inc_nat,
   output logic            active,
   output logic [XLEN-1:0] new_base,
   output logic            new_nat
);
   if (IMMW >= XLEN) begin : g_chk
      $error("immediate wider than register");
   end

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] addend;

   assign imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

   always_comb begin
      active  = 1'b0;
      addend  = '0;
      new_nat = base_nat;
      unique case (base_upd_e'(upd))
         BU_IMM: begin
            active = 1'b1;
            addend = imm_ext;
         end
         BU_REG: begin
            active  = 1'b1;
            addend  = inc;
            new_nat = base_nat | inc_nat;
         end
         default: ;
      endcase
   end

   assign new_base = base + addend;
endmodule

// File: rtl/ldres_unit.sv
module ldres_unit
   import ldres_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int SZ_CODES = 4,
   parameter int IMMW     = 9,
   parameter int REGW     = 7,
   parameter int SPILL_LSB = 3,
   localparam int SZW     = $clog2(SZ_CODES),
   localparam int IDXW    = $clog2(XLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [1:0]      in_form,
   input  logic [SZW-1:0]  in_size,
   input  logic            in_spec,
   input  logic            in_defer,
   input  logic [XLEN-1:0] in_data_lo,
   input  logic [XLEN-1:0] in_data_hi,
   input  logic [XLEN-1:0] in_base,
   input  logic            in_base_nat,
   input  logic [1:0]      in_upd,
   input  logic [IMMW-1:0] in_imm,
   input  logic [XLEN-1:0] in_inc,
   input  logic            in_inc_nat,
   input  logic [XLEN-1:0] in_spill,
   input  logic [REGW-1:0] in_dst_reg,
   input  logic [REGW-1:0] in_base_reg,
   output logic            out_valid,
   output logic            out_dst_we,
   output logic [XLEN-1:0] out_dst_val,
   output logic            out_dst_nat,
   output logic            out_pair_we,
   output logic [XLEN-1:0] out_pair_val,
   output logic            out_base_we,
   output logic [XLEN-1:0] out_base_val,
   output logic            out_base_nat,
   output logic            out_pf_req,
   output logic [XLEN-1:0] out_pf_addr,
   output logic            out_illegal,
   output logic            out_nat_fault
);
   if (XLEN % 8 != 0 || XLEN < 16) begin : g_xchk
      $error("XLEN must be a byte multiple of at least 16");
   end
   if (SPILL_LSB + IDXW > XLEN) begin : g_schk
      $error("spill index field outside the base register");
   end

   logic            upd_act, upd_nat, illegal, natf, fault, deferred;
   logic [XLEN-1:0] upd_base, fmt_val, fmt_pair;
   logic            fmt_nat, fmt_pair_we;

   ldres_baseupd #(.XLEN(XLEN), .IMMW(IMMW)) u_upd (
      .upd(in_upd), .base(in_base), .base_nat(in_base_nat), .imm(in_imm),
      .inc(in_inc), .inc_nat(in_inc_nat), .active(upd_act),
      .new_base(upd_base), .new_nat(upd_nat)
   );

   // alias and paired-with-update checks come before NaT consumption
   assign illegal  = upd_act && ((in_dst_reg == in_base_reg) ||
                                 (ld_form_e'(in_form) == LF_PAIR));
   assign natf     = !illegal && !in_spec && in_base_nat;
   assign fault    = illegal || natf;
   assign deferred = in_defer || (in_spec && in_base_nat);

   ldres_format #(.XLEN(XLEN), .SZ_CODES(SZ_CODES)) u_fmt (
      .form(in_form), .size(in_size), .spec(in_spec), .deferred(deferred),
      .data_lo(in_data_lo), .data_hi(in_data_hi), .spill(in_spill),
      .spill_idx(in_base[SPILL_LSB +: IDXW]),
      .val(fmt_val), .nat(fmt_nat), .pair_val(fmt_pair), .pair_we(fmt_pair_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_dst_we    <= 1'b0;
         out_pair_we   <= 1'b0;
         out_base_we   <= 1'b0;
         out_pf_req    <= 1'b0;
         out_illegal   <= 1'b0;
         out_nat_fault <= 1'b0;
         out_dst_val   <= '0;
         out_dst_nat   <= 1'b0;
         out_pair_val  <= '0;
         out_base_val  <= '0;
         out_base_nat  <= 1'b0;
         out_pf_addr   <= '0;
      end else begin
         out_valid     <= in_valid;
         out_dst_we    <= in_valid && !fault;
         out_pair_we   <= in_valid && !fault && fmt_pair_we;
         out_base_we   <= in_valid && !fault && upd_act;
         out_pf_req    <= in_valid && !fault && upd_act && !upd_nat;
         out_illegal   <= in_valid && illegal;
         out_nat_fault <= in_valid && natf;
         if (in_valid) begin
            out_dst_val  <= fmt_val;
            out_dst_nat  <= fmt_nat;
            out_pair_val <= fmt_pair;
            out_base_val <= upd_base;
            out_base_nat <= upd_nat;
            out_pf_addr  <= upd_base;
         end
      end
   end

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_dst_we && !out_base_we && !out_pf_req);
   // R6
   alias_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_upd == 2'd1 || in_upd == 2'd2) && in_dst_reg == in_base_reg
      |=> out_illegal && !out_base_we && !out_dst_we);
   // R8
   nat_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_spec && in_base_nat && in_upd == 2'd0
      |=> out_nat_fault && !out_dst_we);
   // R9
   pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_pf_req |-> out_base_we && !out_base_nat && out_pf_addr == out_base_val);
   // R5
   inc_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_upd == 2'd2 && in_inc_nat |=> !out_base_we || out_base_nat);
   // R1
   byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_form == 2'd0 && in_size == '0 && !in_defer && !in_base_nat
      && in_upd == 2'd0 |=> out_dst_val[XLEN-1:8] == '0 && !out_dst_nat);
endmodule

// File: tb/tb_ldres_unit.sv
module tb_ldres_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        in_valid = 0, in_spec = 0, in_defer = 0, in_base_nat = 0, in_inc_nat = 0;
   logic [1:0]  in_form = 0, in_size = 0, in_upd = 0;
   logic [63:0] in_data_lo = 0, in_data_hi = 0, in_base = 0, in_inc = 0, in_spill = 0;
   logic [8:0]  in_imm = 0;
   logic [6:0]  in_dst_reg = 0, in_base_reg = 0;

   logic        out_valid, out_dst_we, out_dst_nat, out_pair_we, out_base_we, out_base_nat;
   logic        out_pf_req, out_illegal, out_nat_fault;
   logic [63:0] out_dst_val, out_pair_val, out_base_val, out_pf_addr;

   ldres_unit dut (.*);

   int checks = 0, errors = 0;

   // expected outputs for the load driven last
   bit          e_valid = 0, e_dst_we = 0, e_dst_nat = 0, e_pair_we = 0, e_base_we = 0;
   bit          e_base_nat = 0, e_pf = 0, e_ill = 0, e_natf = 0;
   logic [63:0] e_dst = 0, e_pair = 0, e_base = 0;
   string       e_tag = "R10";
   string       e_btag = "R4";

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("R10", "valid", 64'(out_valid), 64'(e_valid));
      if (e_valid) begin
         chk("R6", "illegal", 64'(out_illegal), 64'(e_ill));
         chk("R8", "nat_fault", 64'(out_nat_fault), 64'(e_natf));
         chk(e_tag, "dst_we", 64'(out_dst_we), 64'(e_dst_we));
         if (e_dst_we) begin
            chk(e_tag, "dst_val", out_dst_val, e_dst);
            chk(e_tag, "dst_nat", 64'(out_dst_nat), 64'(e_dst_nat));
         end
         chk("R3", "pair_we", 64'(out_pair_we), 64'(e_pair_we));
         if (e_pair_we) chk("R3", "pair_val", out_pair_val, e_pair);
         chk(e_btag, "base_we", 64'(out_base_we), 64'(e_base_we));
         if (e_base_we) begin
            chk(e_btag, "base_val", out_base_val, e_base);
            chk("R5", "base_nat", 64'(out_base_nat), 64'(e_base_nat));
         end
         chk("R9", "pf_req", 64'(out_pf_req), 64'(e_pf));
         if (e_pf) chk("R9", "pf_addr", out_pf_addr, e_base);
      end else begin
         chk("R10", "idle enables", {60'd0, out_dst_we, out_pair_we, out_base_we, out_pf_req}, 64'd0);
      end
   endtask

   // behavioural reference of the requirements
   task automatic model();
      bit doupd, defr;
      int nbytes;
      e_valid = in_valid;
      doupd = (in_upd == 2'd1) || (in_upd == 2'd2);
      e_ill  = doupd && ((in_dst_reg == in_base_reg) || in_form == 2'd2);
      e_natf = !e_ill && !in_spec && in_base_nat;
      defr   = in_defer || (in_spec && in_base_nat);
      e_dst_we  = !(e_ill || e_natf);
      e_pair_we = 0;
      e_dst_nat = 0;
      e_dst = 0;
      if (e_ill) e_tag = "R6";
      else if (e_natf) e_tag = "R8";
      else if (defr) begin
         e_tag = "R7";
         e_dst_nat = in_spec;
      end else if (in_form == 2'd1) begin
         e_tag = "R2";
         e_dst = in_data_lo;
         e_dst_nat = in_spill[int'(in_base[8:3])];
      end else if (in_form == 2'd2) begin
         e_tag = "R3";
         e_dst = in_data_lo;
         e_pair = in_data_hi;
         e_pair_we = 1;
      end else begin
         e_tag = "R1";
         nbytes = 1 << in_size;
         for (int b = 0; b < nbytes; b++) e_dst[b*8 +: 8] = in_data_lo[b*8 +: 8];
      end
      e_btag = (in_upd == 2'd2) ? "R5" : "R4";
      if (in_upd == 2'd1) begin
         e_base = in_base + {{55{in_imm[8]}}, in_imm};
         e_base_nat = in_base_nat;
      end else begin
         e_base = in_base + in_inc;
         e_base_nat = in_base_nat | in_inc_nat;
      end
      e_base_we = e_dst_we && doupd;
      e_pf = e_base_we && !e_base_nat;
      if (!in_valid) begin
         e_dst_we = 0; e_pair_we = 0; e_base_we = 0; e_pf = 0; e_ill = 0; e_natf = 0;
      end
   endtask

   task automatic drive(bit v, bit [1:0] form, bit [1:0] sz, bit sp, bit df,
                        bit [1:0] upd, logic [63:0] base, bit bnat, logic [8:0] imm,
                        logic [63:0] inc, bit inat, logic [6:0] dr, logic [6:0] br);
      @(negedge clk);
      compare();
      in_valid = v; in_form = form; in_size = sz; in_spec = sp; in_defer = df;
      in_upd = upd; in_base = base; in_base_nat = bnat; in_imm = imm;
      in_inc = inc; in_inc_nat = inat; in_dst_reg = dr; in_base_reg = br;
      in_data_lo = {$urandom, $urandom} | 64'hFF00_0000_0000_0000;
      in_data_hi = {$urandom, $urandom};
      in_spill = {$urandom, $urandom};
      model();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "reset outputs", {57'd0, out_valid, out_dst_we, out_pair_we, out_base_we,
                                   out_pf_req, out_illegal, out_nat_fault}, 64'd0);
      rst_n = 1'b1;
      // R1 each size
      for (int s = 0; s < 4; s++) drive(1, 0, 2'(s), 0, 0, 0, 64'h1000, 0, 0, 0, 0, 5, 6);
      // R2 fill index sweep
      for (int i = 0; i < 64; i += 7) drive(1, 1, 0, 0, 0, 0, 64'(i) << 3, 0, 0, 0, 0, 5, 6);
      // R3 paired, then paired with update (R6)
      drive(1, 2, 3, 0, 0, 0, 64'h2000, 0, 0, 0, 0, 5, 6);
      drive(1, 2, 3, 0, 0, 1, 64'h2000, 0, 9'h010, 0, 0, 5, 6);
      // R4 negative and positive immediate
      drive(1, 0, 3, 0, 0, 1, 64'h3000, 0, 9'h1F8, 0, 0, 5, 6);
      drive(1, 0, 2, 0, 0, 1, 64'h3000, 0, 9'h0FF, 0, 0, 5, 6);
      // R5 register increment with its NaT
      drive(1, 0, 3, 0, 0, 2, 64'h4000, 0, 0, 64'h40, 1, 5, 6);
      drive(1, 0, 3, 0, 0, 2, 64'h4000, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 5, 6);
      // R6 alias
      drive(1, 0, 3, 0, 0, 2, 64'h5000, 0, 0, 64'h8, 0, 9, 9);
      // R7 deferral variants
      drive(1, 0, 3, 1, 0, 2, 64'h6000, 1, 0, 64'h8, 0, 5, 6);
      drive(1, 0, 3, 0, 1, 0, 64'h6000, 0, 0, 0, 0, 5, 6);
      drive(1, 2, 3, 1, 1, 0, 64'h6000, 0, 0, 0, 0, 5, 6);
      // R8 non-speculative base NaT
      drive(1, 0, 3, 0, 0, 1, 64'h7000, 1, 9'h008, 0, 0, 5, 6);
      // R10 idle gap
      drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 5, 6);
      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         drive(($urandom % 5) != 0, 2'($urandom % 3), 2'($urandom), 1'($urandom),
               ($urandom % 6) == 0, 2'($urandom), {$urandom, $urandom},
               ($urandom % 5) == 0, 9'($urandom), {$urandom, $urandom},
               ($urandom % 4) == 0, 7'($urandom % 4), 7'($urandom % 4));
      end
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      compare();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule